// File: doc/BRIEF.md
# Dual-Rate Converter Output Port Multiplexer

This block sits between three converters and a narrow receive port. One converter gives 10-bit samples and two give 12-bit samples. On every second rising edge of the master clock the block takes a new set of samples. It then sends them out over a two-cycle frame on two registered lanes.

The narrow lane carries the 10-bit word in two 5-bit pieces. A framing strobe marks the cycle that holds the most significant piece. The wide lane has two modes:
- **Interleaved (default):** it carries the two 12-bit converters one after the other.
- **Single:** it repeats one chosen converter for the whole frame.

A power-down input mutes the narrow lane and its strobe. The mode, converter choice and power-down inputs are taken only when a frame starts, so no frame mixes two settings.

Top module: `adc_port_mux`

## Requirements
- R1: Samples are taken only at the first rising edge of each two-cycle frame. Input changes during the second cycle of a frame have no effect on that frame's outputs.
- R2: The narrow lane shows bits 9..5 of the 10-bit sample in the first output cycle of a frame and bits 4..0 in the second.
- R3: The strobe is 1 in the output cycle that carries bits 9..5 and 0 in the other cycle, so it is never high in two cycles in a row.
- R4: In interleaved mode (`single_mode`=0), the wide lane shows converter A's sample in the first cycle of the frame and converter B's sample in the second.
- R5: In single mode (`single_mode`=1), the wide lane shows the same sample in both cycles: converter A when `pick_b`=0, converter B when `pick_b`=1.
- R6: When `narrow_off`=1 at a frame start, the strobe stays 0 and the narrow lane is 0 for that frame. The wide lane behaves as in R4/R5.
- R7: Synchronous active-high reset drives all outputs to 0. The first rising edge after reset is released starts a new frame.
- R8: `single_mode`, `pick_b` and `narrow_off` are taken only at a frame start. A change during the second cycle does not alter the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| narrow_smp | input | 10 | 10-bit converter sample |
| wide_a_smp | input | 12 | 12-bit converter A sample |
| wide_b_smp | input | 12 | 12-bit converter B sample |
| single_mode | input | 1 | 1 = repeat one 12-bit converter for the whole frame |
| pick_b | input | 1 | Converter chosen in single mode (0 = A, 1 = B) |
| narrow_off | input | 1 | 10-bit converter powered down |
| half_o | output | 5 | Narrow lane, half of the 10-bit word |
| wide_o | output | 12 | Wide lane |
| sync_o | output | 1 | Framing strobe for the 10-bit word |

## Verification
The checker tests these on every cycle:
- The strobe never lasts two cycles, and it matches the internal frame phase.
- Whenever the latched power-down setting is 1, the narrow lane and strobe stay at zero.
- In interleaved mode, the wide lane matches the latched A and B samples in the right cycles.
- In single mode, the wide lane is steady across each frame.

The bench scenarios are needed for the rest:
- The exact bit split of the 10-bit word.
- That inputs changed in mid-frame are ignored.
- Frame alignment after reset is released part way through a frame.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    localparam int NARROW_W = 10;
    localparam int WIDE_W   = 12;
    localparam int HALF_W   = NARROW_W / 2;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_TAIL = 1'b1
    } frame_ph_e;

    typedef struct packed {
        logic [NARROW_W-1:0] narrow;
        logic [WIDE_W-1:0]   conv_a;
        logic [WIDE_W-1:0]   conv_b;
    } sample_set_t;

    typedef struct packed {
        logic single;
        logic pick_b;
        logic narrow_off;
    } port_cfg_t;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [WIDE_W-1:0] wide;
        logic              sync;
    } lane_out_t;

    function automatic logic [HALF_W-1:0] upper_half(input logic [NARROW_W-1:0] w);
        return w[NARROW_W-1:HALF_W];
    endfunction

    function automatic logic [HALF_W-1:0] lower_half(input logic [NARROW_W-1:0] w);
        return w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/rx_frame_phase.sv
module rx_frame_phase
    import adc_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output frame_ph_e phase,
    output logic      at_head
);
    frame_ph_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HEAD;
        end else begin
            phase_q <= (phase_q == PH_HEAD) ? PH_TAIL : PH_HEAD;
        end
    end

    assign phase   = phase_q;
    assign at_head = (phase_q == PH_HEAD);
endmodule

// File: rtl/rx_sample_latch.sv
module rx_sample_latch
    import adc_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        at_head,
    input  sample_set_t smp_d,
    input  port_cfg_t   cfg_d,
    output sample_set_t smp_q,
    output port_cfg_t   cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
            cfg_q <= '0;
        end else if (at_head) begin
            smp_q <= smp_d;
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/rx_lane_mux.sv
module rx_lane_mux
    import adc_port_pkg::*;
(
    input  logic        at_head,
    input  sample_set_t smp_live,
    input  port_cfg_t   cfg_live,
    input  sample_set_t smp_held,
    input  port_cfg_t   cfg_held,
    output lane_out_t   nxt
);
    sample_set_t src;
    port_cfg_t   cfg;

    always_comb begin
        src = at_head ? smp_live : smp_held;
        cfg = at_head ? cfg_live : cfg_held;

        if (cfg.narrow_off) begin
            nxt.half = '0;
        end else if (at_head) begin
            nxt.half = upper_half(src.narrow);
        end else begin
            nxt.half = lower_half(src.narrow);
        end

        nxt.sync = at_head & ~cfg.narrow_off;

        if (cfg.single) begin
            nxt.wide = cfg.pick_b ? src.conv_b : src.conv_a;
        end else begin
            nxt.wide = at_head ? src.conv_a : src.conv_b;
        end
    end
endmodule

// File: rtl/adc_port_mux.sv
module adc_port_mux
    import adc_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NARROW_W-1:0] narrow_smp,
    input  logic [WIDE_W-1:0]   wide_a_smp,
    input  logic [WIDE_W-1:0]   wide_b_smp,
    input  logic                single_mode,
    input  logic                pick_b,
    input  logic                narrow_off,
    output logic [HALF_W-1:0]   half_o,
    output logic [WIDE_W-1:0]   wide_o,
    output logic                sync_o
);
    frame_ph_e   phase;
    logic        at_head;
    sample_set_t smp_live;
    port_cfg_t   cfg_live;
    sample_set_t smp_q;
    port_cfg_t   cfg_q;
    lane_out_t   nxt;
    lane_out_t   out_q;

    assign smp_live = '{narrow: narrow_smp, conv_a: wide_a_smp, conv_b: wide_b_smp};
    assign cfg_live = '{single: single_mode, pick_b: pick_b, narrow_off: narrow_off};

    rx_frame_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .at_head (at_head)
    );

    rx_sample_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .at_head (at_head),
        .smp_d   (smp_live),
        .cfg_d   (cfg_live),
        .smp_q   (smp_q),
        .cfg_q   (cfg_q)
    );

    rx_lane_mux u_mux (
        .at_head  (at_head),
        .smp_live (smp_live),
        .cfg_live (cfg_live),
        .smp_held (smp_q),
        .cfg_held (cfg_q),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign half_o = out_q.half;
    assign wide_o = out_q.wide;
    assign sync_o = out_q.sync;
endmodule

// File: rtl/adc_port_mux_chk.sv
module adc_port_mux_chk
    import adc_port_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input frame_ph_e           phase,
    input sample_set_t         smp_q,
    input port_cfg_t           cfg_q,
    input logic [HALF_W-1:0]   half_o,
    input logic [WIDE_W-1:0]   wide_o,
    input logic                sync_o
);
    // R3
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);

    // R3
    strobe_phase_align_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> phase == PH_TAIL);

    // R6
    narrow_mute_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.narrow_off |-> (half_o == '0 && !sync_o));

    // R4
    interleave_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.single && phase == PH_TAIL) |-> wide_o == smp_q.conv_a);

    // R4
    interleave_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.single && phase == PH_HEAD) |-> wide_o == smp_q.conv_b);

    // R5
    single_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.single && phase == PH_TAIL) |=> $stable(wide_o));
endmodule

bind adc_port_mux adc_port_mux_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .smp_q  (smp_q),
    .cfg_q  (cfg_q),
    .half_o (half_o),
    .wide_o (wide_o),
    .sync_o (sync_o)
);

// File: tb/adc_port_mux_tb.sv
module adc_port_mux_tb;
    typedef struct packed {
        logic [9:0]  n;
        logic [11:0] a;
        logic [11:0] b;
        logic        s;
        logic        p;
        logic        o;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'h2CD, 12'hA5A, 12'h3C3, 1'b0, 1'b0, 1'b0},
        '{10'h155, 12'hFFF, 12'h000, 1'b0, 1'b1, 1'b0},
        '{10'h2AA, 12'h123, 12'h456, 1'b1, 1'b0, 1'b0},
        '{10'h0F0, 12'h789, 12'hABC, 1'b1, 1'b1, 1'b0},
        '{10'h3FF, 12'h111, 12'h222, 1'b0, 1'b0, 1'b1},
        '{10'h001, 12'h800, 12'h001, 1'b1, 1'b1, 1'b1},
        '{10'h200, 12'hFED, 12'hCBA, 1'b0, 1'b1, 1'b0},
        '{10'h1E3, 12'h0F0, 12'h00F, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  narrow_smp = '0;
    logic [11:0] wide_a_smp = '0;
    logic [11:0] wide_b_smp = '0;
    logic        single_mode = 1'b0;
    logic        pick_b = 1'b0;
    logic        narrow_off = 1'b0;
    logic [4:0]  half_o;
    logic [11:0] wide_o;
    logic        sync_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    adc_port_mux u_dut (
        .clk (clk), .rst (rst),
        .narrow_smp (narrow_smp), .wide_a_smp (wide_a_smp), .wide_b_smp (wide_b_smp),
        .single_mode (single_mode), .pick_b (pick_b), .narrow_off (narrow_off),
        .half_o (half_o), .wide_o (wide_o), .sync_o (sync_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        narrow_smp = v.n; wide_a_smp = v.a; wide_b_smp = v.b;
        single_mode = v.s; pick_b = v.p; narrow_off = v.o;
    endtask

    // c = 0 first cycle of frame, 1 second cycle
    task automatic expect_cycle(input vec_t v, input int c);
        logic [4:0]  eh;
        logic [11:0] ew;
        logic        es;
        eh = v.o ? 5'd0 : (c == 0 ? v.n[9:5] : v.n[4:0]);
        es = (c == 0) && !v.o;
        ew = v.s ? (v.p ? v.b : v.a) : (c == 0 ? v.a : v.b);
        check(v.o ? "R6 half" : "R2 half", 32'(half_o), 32'(eh));
        check(v.o ? "R6 sync" : "R3 sync", 32'(sync_o), 32'(es));
        check(v.s ? "R5 wide" : "R4 wide", 32'(wide_o), 32'(ew));
    endtask

    // Tail inputs are inverted to show they have no effect (R1, R8)
    task automatic run_frame(input vec_t v);
        drive(v);
        @(negedge clk);
        expect_cycle(v, 0);
        drive(~v);
        @(negedge clk);
        expect_cycle(v, 1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 half", 32'(half_o), 0);
        check("R7 wide", 32'(wide_o), 0);
        check("R7 sync", 32'(sync_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i]);
        end

        // R7 reset in mid-frame, then realign
        drive(VECS[1]);
        @(negedge clk);
        expect_cycle(VECS[1], 0);
        rst = 1'b1;
        @(negedge clk);
        check("R7 half mid", 32'(half_o), 0);
        check("R7 wide mid", 32'(wide_o), 0);
        check("R7 sync mid", 32'(sync_o), 0);
        rst = 1'b0;
        run_frame(VECS[6]);
        run_frame(VECS[2]);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule